// File: doc/BRIEF.md
# Repeater Statistics Register File

This block is the host-visible register file of a managed multiport Ethernet repeater. A host reaches it through an 8-bit bus made of an active-low chip select, separate active-low read and write strobes, and a command/data select line. Each strobe is acted on once, on the first clock in which it is seen low with chip select low. A bare read of the command port returns a status byte. Two command-port writes select a register. The first gives a 5-bit bank and the second gives a 5-bit register. Data-port reads and writes then move the selected value one byte at a time, least significant byte first.

The file holds the following values:
- Repeater-wide total-octet and transmit-collision counters.
- Per-port frames-too-long and data-rate-mismatch counters.
- A 6-byte source address match value.
- A configuration byte and a fixed identification byte.
- Per-port link-change cause bits, each with its own interrupt enable.

Event strobes from the repeater core increment the counters, and the counters stop at all ones. A reset clears the selection and control state but does not touch any counter. The interrupt line is active low. It stays asserted while any enabled cause bit is set, until the host clears that bit.

Top module: `rpt_stat_regs`

## Requirements
- R1: A command-port read (cd=1) returns the status byte. Bit 7 is 1 when any enabled link-change cause is pending, bit 0 is the management error flag, and bits 6:1 read 0.
- R2: The first command-port write after reset, or after a completed pair, loads the bank from din[4:0]. The next write loads the register from din[4:0] and sets the byte index to 0. Each data-port read or write then advances the byte index by one, up to a limit of 7.
- R3: A counter reads as four data-port reads: byte 0 gives bits 7:0, byte 1 gives bits 15:8, byte 2 gives bits 23:16 and byte 3 gives bits 31:24. The byte 0 read captures all 32 bits, so bytes 1 to 3 come from that capture even if the counter increments during the read.
- R4: Every counter saturates at all ones. A further event leaves it at all ones.
- R5: An active-low reset clears the selection state, configuration, interrupt enables, cause bits, error flag and address match value. All counter values are retained.
- R6: The following registers are in bank 0. Register 10 is a 6-byte read/write address match value, byte 0 first. Register 16 is a read/write configuration byte. Register 28 reads the fixed ID 0xA5.
- R7: The following registers are 1-byte registers in which bit p belongs to port p. Bank 1 register 0 holds the link-change cause bits: a strobe on link_chg[p] sets bit p, and writing a 1 to bit p clears it. Bank 2 register 0 holds the interrupt enables. int_n goes low in the cycle after an enabled cause bit is set. It stays low until every enabled cause bit has been cleared.
- R8: A data write to a counter or to the ID register changes nothing and sets the status error flag. A command-port read clears the flag.
- R9: Reserved locations read as 0 and ignore writes without setting the error flag. This includes unlisted banks, unlisted registers, and attribute banks above the last port.
- R10: Bank 16+p holds the counters of port p: register 0 counts frames too long (ev_toolong[p]) and register 1 counts data rate mismatches (ev_ratemis[p]). Bank 0 register 12 counts ev_octet and register 13 counts ev_txcol. Each counter increments only on its own strobe, by one per cycle in which the strobe is high.
- R11: A data read past the length of the selected register returns 0. A data write past its length is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| cs_n | input | 1 | Active-low chip select |
| cd | input | 1 | Port select: 1 command port, 0 data port |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data (status byte when cd=1) |
| int_n | output | 1 | Active-low interrupt |
| ev_octet | input | 1 | Total-octet increment strobe |
| ev_txcol | input | 1 | Transmit-collision increment strobe |
| ev_toolong | input | NPORTS | Per-port frames-too-long strobes |
| ev_ratemis | input | NPORTS | Per-port data-rate-mismatch strobes |
| link_chg | input | NPORTS | Per-port link state change strobes |

## Verification
Two situations are hard to bring about from the ports.

The first is a counter that moves partway through its own byte-serial read. To reach it, the bench drives a port counter to 0x0FF and reads byte 0. It then fires one event before reading byte 1, so a live read would show a carry and a correct snapshot shows none.

The second is saturation. It would need billions of events at full width, so the bench builds the block with a 10-bit counter width and holds the octet strobe high past 1023 cycles.

// File: rtl/rpt_stat_regs.sv
module rpt_stat_regs #(
  parameter int NPORTS = 8,
  parameter int CNT_W = 32,
  parameter logic [7:0] ID_VAL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cd,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              int_n,
  input  logic              ev_octet,
  input  logic              ev_txcol,
  input  logic [NPORTS-1:0] ev_toolong,
  input  logic [NPORTS-1:0] ev_ratemis,
  input  logic [NPORTS-1:0] link_chg
);

  localparam logic [4:0] B_RPT = 5'd0;
  localparam logic [4:0] B_PST = 5'd1;
  localparam logic [4:0] B_PCT = 5'd2;
  localparam logic [4:0] R_SA  = 5'd10;
  localparam logic [4:0] R_OCT = 5'd12;
  localparam logic [4:0] R_TXC = 5'd13;
  localparam logic [4:0] R_CFG = 5'd16;
  localparam logic [4:0] R_ID  = 5'd28;
  localparam logic [4:0] NP5   = 5'(NPORTS);
  localparam logic [7:0] PMASK = 8'((1 << NPORTS) - 1);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic rd_q, wr_q;
  logic [4:0] bank, regsel;
  logic ph;
  logic [2:0] idx;
  logic [7:0] cfg, en, cause;
  logic err;
  logic [47:0] sa;
  logic [31:0] snap;

  logic [CNT_W-1:0] oct, txc;
  logic [CNT_W-1:0] too_c [NPORTS];
  logic [CNT_W-1:0] mis_c [NPORTS];

  wire rd_act = ~cs_n & ~rd_n;
  wire wr_act = ~cs_n & ~wr_n;
  wire rd_p = rd_act & rd_q;
  wire wr_p = wr_act & wr_q;
  wire c_rd = rd_p & cd;
  wire d_rd = rd_p & ~cd;
  wire c_wr = wr_p & cd;
  wire d_wr = wr_p & ~cd;

  wire is_att = bank[4] && ({1'b0, bank[3:0]} < NP5);
  wire irq = |(cause & en);

  logic [47:0] cur, src;
  logic [31:0] live;
  logic [2:0] len;
  logic is_cnt, ro;
  logic [7:0] d_byte, clr;

  always_comb begin
    cur = '0;
    live = '0;
    len = 3'd0;
    is_cnt = 1'b0;
    ro = 1'b0;
    if (bank == B_RPT) begin
      case (regsel)
        R_SA:  begin cur = sa; len = 3'd6; end
        R_OCT: begin live = 32'(oct); is_cnt = 1'b1; end
        R_TXC: begin live = 32'(txc); is_cnt = 1'b1; end
        R_CFG: begin cur = 48'(cfg); len = 3'd1; end
        R_ID:  begin cur = 48'(ID_VAL); len = 3'd1; ro = 1'b1; end
        default: ;
      endcase
    end else if (bank == B_PST && regsel == 5'd0) begin
      cur = 48'(cause);
      len = 3'd1;
    end else if (bank == B_PCT && regsel == 5'd0) begin
      cur = 48'(en);
      len = 3'd1;
    end else if (is_att) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (bank[3:0] == 4'(p)) begin
          if (regsel == 5'd0) begin live = 32'(too_c[p]); is_cnt = 1'b1; end
          if (regsel == 5'd1) begin live = 32'(mis_c[p]); is_cnt = 1'b1; end
        end
      end
    end
    if (is_cnt) begin
      cur = {16'b0, live};
      len = 3'd4;
      ro = 1'b1;
    end
  end

  assign src = (is_cnt && idx != 3'd0) ? {16'b0, snap} : cur;
  assign d_byte = (idx < len) ? 8'(src >> {idx, 3'b000}) : 8'h00;
  assign dout = cd ? {irq, 6'b0, err} : d_byte;
  assign int_n = ~irq;
  assign clr = (d_wr && bank == B_PST && regsel == 5'd0 && idx == 3'd0) ? din : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
      bank <= '0;
      regsel <= '0;
      ph <= 1'b0;
      idx <= '0;
      cfg <= '0;
      en <= '0;
      cause <= '0;
      err <= 1'b0;
      sa <= '0;
      snap <= '0;
    end else begin
      rd_q <= ~rd_act;
      wr_q <= ~wr_act;
      cause <= ((cause & ~clr) | 8'(link_chg)) & PMASK;
      if (c_wr) begin
        if (!ph) begin
          bank <= din[4:0];
          ph <= 1'b1;
        end else begin
          regsel <= din[4:0];
          idx <= 3'd0;
          ph <= 1'b0;
        end
      end
      if ((d_rd || d_wr) && idx != 3'd7)
        idx <= idx + 3'd1;
      if (d_rd && is_cnt && idx == 3'd0)
        snap <= live;
      if (c_rd)
        err <= 1'b0;
      if (d_wr && ro)
        err <= 1'b1;
      if (d_wr && !ro && idx < len) begin
        if (bank == B_RPT && regsel == R_SA) begin
          for (int b = 0; b < 6; b++)
            if (idx == 3'(b)) sa[8*b +: 8] <= din;
        end
        if (bank == B_RPT && regsel == R_CFG)
          cfg <= din;
        if (bank == B_PCT && regsel == 5'd0)
          en <= din & PMASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ev_octet && oct != '1) oct <= oct + ONE;
    if (ev_txcol && txc != '1) txc <= txc + ONE;
    for (int p = 0; p < NPORTS; p++) begin
      if (ev_toolong[p] && too_c[p] != '1) too_c[p] <= too_c[p] + ONE;
      if (ev_ratemis[p] && mis_c[p] != '1) mis_c[p] <= mis_c[p] + ONE;
    end
  end

endmodule

// File: rtl/rpt_stat_regs_chk.sv
module rpt_stat_regs_chk #(
  parameter int NPORTS = 8,
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cd,
  input logic              rd_n,
  input logic              wr_n,
  input logic [7:0]        dout,
  input logic              int_n,
  input logic              ev_octet,
  input logic [NPORTS-1:0] link_chg,
  input logic [7:0]        en,
  input logic              err,
  input logic              ph,
  input logic [2:0]        idx,
  input logic [CNT_W-1:0]  oct
);

  p_status_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cd) |-> (dout[7] == !int_n));

  p_idx_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cd && !wr_n && $past(wr_n || cs_n) && ph) |=> (idx == 3'd0));

  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oct == '1) |=> (oct == '1));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oct != $past(oct)) |-> (oct == $past(oct) + {{(CNT_W-1){1'b0}}, 1'b1}));

  p_int_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(8'(link_chg) & en)) && (wr_n || cs_n)) |=> !int_n);

  p_int_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && (wr_n || cs_n)) |=> !int_n);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cd && !rd_n && $past(rd_n || cs_n) && (wr_n || cs_n)) |=> !err);

endmodule

bind rpt_stat_regs rpt_stat_regs_chk #(.NPORTS(NPORTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
  .dout(dout), .int_n(int_n), .ev_octet(ev_octet), .link_chg(link_chg),
  .en(en), .err(err), .ph(ph), .idx(idx), .oct(oct)
);

// File: tb/rpt_stat_regs_tb.sv
module rpt_stat_regs_tb;
  localparam int NP = 8;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, cd = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic int_n;
  logic ev_octet = 1'b0, ev_txcol = 1'b0;
  logic [NP-1:0] ev_toolong = '0, ev_ratemis = '0, link_chg = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rpt_stat_regs #(.NPORTS(NP), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .dout(dout), .int_n(int_n), .ev_octet(ev_octet), .ev_txcol(ev_txcol),
    .ev_toolong(ev_toolong), .ev_ratemis(ev_ratemis), .link_chg(link_chg)
  );

  // op: 0 C write, 1 D write, 2 C read, 3 D read; grp 0 = no check
  localparam int NV = 41;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h1C, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'hA5, 4'd6}, {2'd3, 8'h00, 8'h00, 4'd11},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h10, 8'h00, 4'd0},
    {2'd1, 8'h3C, 8'h00, 4'd0},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h10, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'h3C, 4'd6},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h0A, 8'h00, 4'd0},
    {2'd1, 8'h11, 8'h00, 4'd0}, {2'd1, 8'h22, 8'h00, 4'd0},
    {2'd1, 8'h33, 8'h00, 4'd0}, {2'd1, 8'h44, 8'h00, 4'd0},
    {2'd1, 8'h55, 8'h00, 4'd0}, {2'd1, 8'h66, 8'h00, 4'd0},
    {2'd1, 8'h77, 8'h00, 4'd0},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h0A, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'h11, 4'd2}, {2'd3, 8'h00, 8'h22, 4'd6},
    {2'd3, 8'h00, 8'h33, 4'd6}, {2'd3, 8'h00, 8'h44, 4'd6},
    {2'd3, 8'h00, 8'h55, 4'd6}, {2'd3, 8'h00, 8'h66, 4'd6},
    {2'd3, 8'h00, 8'h00, 4'd11},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h05, 8'h00, 4'd0},
    {2'd1, 8'h5A, 8'h00, 4'd0},
    {2'd0, 8'h00, 8'h00, 4'd0}, {2'd0, 8'h05, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'h00, 4'd9}, {2'd2, 8'h00, 8'h00, 4'd9},
    {2'd0, 8'h03, 8'h00, 4'd0}, {2'd0, 8'h00, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'h00, 4'd9},
    {2'd0, 8'h18, 8'h00, 4'd0}, {2'd0, 8'h00, 8'h00, 4'd0},
    {2'd3, 8'h00, 8'h00, 4'd9}
  };

  function automatic string tagname(input logic [3:0] g);
    case (g)
      4'd2:  return "R2";
      4'd6:  return "R6";
      4'd9:  return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic c, input logic w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs_n = 1'b0;
    cd = c;
    din = d;
    if (w) wr_n = 1'b0; else rd_n = 1'b0;
    #2 q = dout;
    @(negedge clk);
    cs_n = 1'b1;
    wr_n = 1'b1;
    rd_n = 1'b1;
  endtask

  task automatic cwr(input logic [7:0] d); logic [7:0] q; acc(1'b1, 1'b1, d, q); endtask
  task automatic dwr(input logic [7:0] d); logic [7:0] q; acc(1'b0, 1'b1, d, q); endtask
  task automatic crd(output logic [7:0] q); acc(1'b1, 1'b0, 8'h00, q); endtask
  task automatic drd(output logic [7:0] q); acc(1'b0, 1'b0, 8'h00, q); endtask
  task automatic sel(input logic [4:0] b, input logic [4:0] r); cwr(8'(b)); cwr(8'(r)); endtask

  task automatic rdcnt(input logic [4:0] b, input logic [4:0] r, output logic [31:0] v);
    logic [7:0] q;
    sel(b, r);
    for (int i = 0; i < 4; i++) begin
      drd(q);
      v[8*i +: 8] = q;
    end
  endtask

  task automatic fire_too(input int p, input int n);
    repeat (n) begin @(negedge clk); ev_toolong[p] = 1'b1; @(negedge clk); ev_toolong[p] = 1'b0; end
  endtask
  task automatic fire_mis(input int p, input int n);
    repeat (n) begin @(negedge clk); ev_ratemis[p] = 1'b1; @(negedge clk); ev_ratemis[p] = 1'b0; end
  endtask
  task automatic fire_txc(input int n);
    repeat (n) begin @(negedge clk); ev_txcol = 1'b1; @(negedge clk); ev_txcol = 1'b0; end
  endtask
  task automatic fire_link(input int p);
    @(negedge clk); link_chg[p] = 1'b1; @(negedge clk); link_chg[p] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    logic [31:0] v, b_too2, b_mis5, b_txc, b_too5, b_mis2, b0, oct_v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    crd(q);
    chk("R1 status after reset", 32'(q), 32'h00);
    chk("R5 int_n after reset", 32'(int_n), 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][21:20];
      acc(~op[0], ~op[1], VEC[i][19:12], q);
      if (VEC[i][3:0] != 4'd0)
        chk(tagname(VEC[i][3:0]), 32'(q), 32'(VEC[i][11:4]));
    end

    // R10: each counter follows only its own strobe
    rdcnt(5'd18, 5'd0, b_too2);
    rdcnt(5'd21, 5'd1, b_mis5);
    rdcnt(5'd21, 5'd0, b_too5);
    rdcnt(5'd18, 5'd1, b_mis2);
    rdcnt(5'd0, 5'd13, b_txc);
    fire_too(2, 3);
    fire_mis(5, 5);
    fire_txc(2);
    rdcnt(5'd18, 5'd0, v);  chk("R10 too long port 2", v, b_too2 + 3);
    rdcnt(5'd21, 5'd1, v);  chk("R10 rate mismatch port 5", v, b_mis5 + 5);
    rdcnt(5'd21, 5'd0, v);  chk("R10 too long port 5 untouched", v, b_too5);
    rdcnt(5'd18, 5'd1, v);  chk("R10 rate mismatch port 2 untouched", v, b_mis2);
    rdcnt(5'd0, 5'd13, v);  chk("R10 transmit collisions", v, b_txc + 2);

    // R3: snapshot keeps bytes 1..3 consistent with byte 0
    rdcnt(5'd16, 5'd0, b0);
    if (b0 <= 32'd255) begin
      fire_too(0, 255 - int'(b0));
      sel(5'd16, 5'd0);
      drd(q); chk("R3 byte 0", 32'(q), 32'hFF);
      fire_too(0, 1);
      drd(q); chk("R3 byte 1 from snapshot", 32'(q), 32'h00);
      drd(q); chk("R3 byte 2", 32'(q), 32'h00);
      drd(q); chk("R3 byte 3", 32'(q), 32'h00);
      rdcnt(5'd16, 5'd0, v); chk("R3 fresh read after event", v, 32'h100);
    end

    // R4: saturation at the configured width
    @(negedge clk); ev_octet = 1'b1;
    repeat (1100) @(negedge clk);
    ev_octet = 1'b0;
    rdcnt(5'd0, 5'd12, v); chk("R4 octets saturated", v, 32'h3FF);
    @(negedge clk); ev_octet = 1'b1; @(negedge clk); ev_octet = 1'b0;
    rdcnt(5'd0, 5'd12, oct_v); chk("R4 octets hold after extra event", oct_v, 32'h3FF);

    // R8: writes to read-only registers
    sel(5'd0, 5'd12);
    dwr(8'h77);
    crd(q); chk("R8 error after counter write", 32'(q), 32'h01);
    crd(q); chk("R8 error cleared by status read", 32'(q), 32'h00);
    rdcnt(5'd0, 5'd12, v); chk("R8 counter unchanged", v, 32'h3FF);
    sel(5'd0, 5'd28);
    dwr(8'h00);
    crd(q); chk("R8 error after ID write", 32'(q), 32'h01);
    sel(5'd0, 5'd28);
    drd(q); chk("R8 ID unchanged", 32'(q), 32'hA5);

    // R7: link change causes and enables
    sel(5'd2, 5'd0); dwr(8'h08);
    fire_link(5);
    chk("R7 disabled cause leaves int_n high", 32'(int_n), 32'h1);
    crd(q); chk("R1 no pending interrupt", 32'(q), 32'h00);
    fire_link(3);
    chk("R7 enabled cause drives int_n low", 32'(int_n), 32'h0);
    crd(q); chk("R1 status interrupt bit", 32'(q), 32'h80);
    sel(5'd1, 5'd0); drd(q); chk("R7 cause bits", 32'(q), 32'h28);
    sel(5'd1, 5'd0); dwr(8'h20);
    chk("R7 clearing disabled cause keeps int_n low", 32'(int_n), 32'h0);
    sel(5'd1, 5'd0); dwr(8'h08);
    chk("R7 clearing enabled cause releases int_n", 32'(int_n), 32'h1);
    sel(5'd1, 5'd0); drd(q); chk("R7 cause bits cleared", 32'(q), 32'h00);

    // R5: reset clears control, keeps counters
    sel(5'd2, 5'd0); dwr(8'h02);
    fire_link(1);
    chk("R5 int_n low before reset", 32'(int_n), 32'h0);
    rdcnt(5'd18, 5'd0, b_too2);
    sel(5'd0, 5'd12); dwr(8'h00);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R5 int_n released by reset", 32'(int_n), 32'h1);
    crd(q); chk("R5 status cleared", 32'(q), 32'h00);
    sel(5'd0, 5'd16); drd(q); chk("R5 config cleared", 32'(q), 32'h00);
    sel(5'd2, 5'd0); drd(q); chk("R5 enables cleared", 32'(q), 32'h00);
    sel(5'd0, 5'd10); drd(q); chk("R5 address match cleared", 32'(q), 32'h00);
    rdcnt(5'd0, 5'd12, v); chk("R5 octets retained", v, 32'h3FF);
    rdcnt(5'd18, 5'd0, v); chk("R5 port counter retained", v, b_too2);

    finish_run();
  end
endmodule